// File: doc/BRIEF.md
# Residue FIR Channel, Modulus 2^N − 1

This block is one arithmetic lane of a residue-number FIR filter. It works on a single modulus, M = 2^N − 1, and runs alongside sibling lanes that handle the other moduli. Binary-to-residue and residue-to-binary conversion happen outside the block. Each accepted input residue enters a tap history. Every tap is multiplied by a fixed coefficient residue set at elaboration, and the weighted sum is delivered as one N-bit residue.

For this modulus a product needs no multiplier array. Each set bit of a coefficient adds a cyclic left rotation of the tap value. The block gathers the rotated words of all taps and reduces them together in one carry-save structure of plain full adders. In that structure the carry word is rotated rather than shifted, so the running pair stays N bits wide no matter how many terms are added. A single end-around-carry adder then folds the final pair into a residue, with zero always shown as all zeros. A parameter chooses whether a register sits between the carry-save array and that final adder.

Top module: `rnsfir_channel`

## Requirements
- R1: When `out_valid` is high, `out_res` equals (C0·x0 + C1·x1 + … + C(TAPS−1)·x(TAPS−1)) mod (2^N − 1). Here x0 is the most recently accepted input and xj the one accepted j inputs earlier. Cj is the field `COEF_VEC[j*N +: N]`.
- R2: `out_res` is never all ones. A zero result is presented as all zeros.
- R3: An input or coefficient of all ones is accepted and acts as the value zero.
- R4: Each cycle with `in_valid` high shifts the tap history by one and loads `in_res` as x0. Cycles with `in_valid` low leave the history unchanged, so idle gaps do not alter later results.
- R5: `out_valid` goes high exactly once per accepted input. If `in_valid` is sampled high at rising edge t, `out_valid` is high after edge t + LATENCY − 1. LATENCY is 3 with the registered carry-save stage and 2 without it.
- R6: While `out_valid` is low, `out_res` keeps its last value.
- R7: Asserting `rst_n` low clears the tap history to zero, drives `out_valid` low and sets `out_res` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Accept `in_res` this cycle |
| in_res | input | N | Input residue modulo 2^N − 1 |
| out_valid | output | 1 | `out_res` carries a new filter result |
| out_res | output | N | Filter result residue, canonical form |

## Verification
The latency property assumes that `in_valid` is low while reset is asserted. It also assumes that no input is still in the pipeline when reset is applied, because it compares `out_valid` with `in_valid` from a fixed number of cycles earlier. The stimulus follows both rules: `in_valid` stays low during reset, and the pipeline is drained with idle cycles before the mid-run reset. Input values sweep every ordered pair of the 16 possible codes of a 4-bit lane, including the all-ones alias of zero. Idle gaps are inserted at a value-dependent rhythm.

// File: rtl/rnsfir_pkg.sv
package rnsfir_pkg;

   localparam int unsigned MIN_WIDTH = 2;
   localparam int unsigned MAX_WIDTH = 16;

   typedef enum logic {
      CSA_COMB = 1'b0,
      CSA_REG  = 1'b1
   } csa_stage_e;

   function automatic int unsigned chan_latency(csa_stage_e st);
      return (st == CSA_REG) ? 3 : 2;
   endfunction

endpackage

// File: rtl/rnsfir_tapline.sv
module rnsfir_tapline #(
   parameter int unsigned N    = 5,
   parameter int unsigned TAPS = 4,
   localparam int unsigned FLAT_W = N * TAPS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic [N-1:0]      din,
   output logic [FLAT_W-1:0] taps_flat
);

   logic [N-1:0] stage_q [TAPS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q[0] <= '0;
      end else if (shift_en) begin
         stage_q[0] <= din;
      end
   end

   for (genvar t = 1; t < TAPS; t++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[t] <= '0;
         end else if (shift_en) begin
            stage_q[t] <= stage_q[t-1];
         end
      end
   end

   for (genvar t = 0; t < TAPS; t++) begin : g_flat
      assign taps_flat[t*N +: N] = stage_q[t];
   end

endmodule

// File: rtl/rnsfir_ppgen.sv
module rnsfir_ppgen #(
   parameter int unsigned N    = 5,
   parameter int unsigned TAPS = 4,
   parameter logic [N*TAPS-1:0] COEF_VEC = '1,
   localparam int unsigned TERMS = N * TAPS
) (
   input  logic [N*TAPS-1:0]  taps_flat,
   output logic [TERMS*N-1:0] terms_flat
);

   for (genvar j = 0; j < TAPS; j++) begin : g_tap
      for (genvar b = 0; b < N; b++) begin : g_bit
         localparam int unsigned IDX = j * N + b;
         if (COEF_VEC[IDX] == 1'b0) begin : g_zero
            assign terms_flat[IDX*N +: N] = '0;
         end else if (b == 0) begin : g_plain
            assign terms_flat[IDX*N +: N] = taps_flat[j*N +: N];
         end else begin : g_rot
            assign terms_flat[IDX*N +: N] = {taps_flat[j*N +: N-b],
                                             taps_flat[j*N+N-b +: b]};
         end
      end
   end

endmodule

// File: rtl/rnsfir_csa_array.sv
module rnsfir_csa_array #(
   parameter int unsigned N     = 5,
   parameter int unsigned TERMS = 20
) (
   input  logic [TERMS*N-1:0] terms_flat,
   output logic [N-1:0]       sum_o,
   output logic [N-1:0]       cry_o
);

   logic [N-1:0] acc_s [TERMS-1];
   logic [N-1:0] acc_c [TERMS-1];

   assign acc_s[0] = terms_flat[0 +: N];
   assign acc_c[0] = terms_flat[N +: N];

   for (genvar i = 1; i < TERMS - 1; i++) begin : g_fa_row
      logic [N-1:0] nxt;
      logic [N-1:0] maj;
      assign nxt      = terms_flat[(i+1)*N +: N];
      assign acc_s[i] = acc_s[i-1] ^ acc_c[i-1] ^ nxt;
      assign maj      = (acc_s[i-1] & acc_c[i-1]) |
                        (acc_s[i-1] & nxt) |
                        (acc_c[i-1] & nxt);
      assign acc_c[i] = {maj[N-2:0], maj[N-1]};
   end

   assign sum_o = acc_s[TERMS-2];
   assign cry_o = acc_c[TERMS-2];

endmodule

// File: rtl/rnsfir_modadd.sv
module rnsfir_modadd #(
   parameter int unsigned N = 5
) (
   input  logic [N-1:0] a,
   input  logic [N-1:0] b,
   output logic [N-1:0] y
);

   logic [N:0]   raw;
   logic [N-1:0] fold;

   assign raw  = {1'b0, a} + {1'b0, b};
   assign fold = raw[N-1:0] + {{(N-1){1'b0}}, raw[N]};
   assign y    = (&fold) ? '0 : fold;

endmodule

// File: rtl/rnsfir_channel.sv
module rnsfir_channel #(
   parameter int unsigned N    = 5,
   parameter int unsigned TAPS = 4,
   parameter logic [N*TAPS-1:0] COEF_VEC = {5'd9, 5'd31, 5'd17, 5'd3},
   parameter rnsfir_pkg::csa_stage_e CSA_STAGE = rnsfir_pkg::CSA_REG
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [N-1:0] in_res,
   output logic         out_valid,
   output logic [N-1:0] out_res
);

   localparam int unsigned TERMS   = N * TAPS;
   localparam int unsigned LATENCY = rnsfir_pkg::chan_latency(CSA_STAGE);

   if (N < rnsfir_pkg::MIN_WIDTH || N > rnsfir_pkg::MAX_WIDTH) begin : g_bad_width
      $error("rnsfir_channel: N out of supported range");
   end
   if (TAPS < 1) begin : g_bad_taps
      $error("rnsfir_channel: TAPS must be at least 1");
   end

   logic [N*TAPS-1:0]  tap_flat;
   logic [TERMS*N-1:0] term_flat;
   logic [N-1:0]       csa_s;
   logic [N-1:0]       csa_c;
   logic [N-1:0]       st_s;
   logic [N-1:0]       st_c;
   logic               st_vld;
   logic               tap_vld_q;
   logic [N-1:0]       sum_res;

   rnsfir_tapline #(.N(N), .TAPS(TAPS)) tapline_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (in_valid),
      .din       (in_res),
      .taps_flat (tap_flat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tap_vld_q <= 1'b0;
      end else begin
         tap_vld_q <= in_valid;
      end
   end

   rnsfir_ppgen #(.N(N), .TAPS(TAPS), .COEF_VEC(COEF_VEC)) ppgen_i (
      .taps_flat  (tap_flat),
      .terms_flat (term_flat)
   );

   rnsfir_csa_array #(.N(N), .TERMS(TERMS)) csa_i (
      .terms_flat (term_flat),
      .sum_o      (csa_s),
      .cry_o      (csa_c)
   );

   if (CSA_STAGE == rnsfir_pkg::CSA_REG) begin : g_csa_reg
      logic [N-1:0] s_q;
      logic [N-1:0] c_q;
      logic         v_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s_q <= '0;
            c_q <= '0;
            v_q <= 1'b0;
         end else begin
            v_q <= tap_vld_q;
            if (tap_vld_q) begin
               s_q <= csa_s;
               c_q <= csa_c;
            end
         end
      end
      assign st_s   = s_q;
      assign st_c   = c_q;
      assign st_vld = v_q;
   end else begin : g_csa_comb
      assign st_s   = csa_s;
      assign st_c   = csa_c;
      assign st_vld = tap_vld_q;
   end

   rnsfir_modadd #(.N(N)) modadd_i (
      .a (st_s),
      .b (st_c),
      .y (sum_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_res   <= '0;
      end else begin
         out_valid <= st_vld;
         if (st_vld) begin
            out_res <= sum_res;
         end
      end
   end

endmodule

// File: rtl/rnsfir_channel_chk.sv
module rnsfir_channel_chk #(
   parameter int unsigned N    = 5,
   parameter int unsigned TAPS = 4,
   parameter int unsigned LAT  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [N-1:0]      in_res,
   input logic              out_valid,
   input logic [N-1:0]      out_res,
   input logic [N*TAPS-1:0] tap_flat
);

   assert_canonical_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_res != '1));

   assert_taps_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(tap_flat));

   assert_tap_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (tap_flat[N-1:0] == $past(in_res)));

   assert_valid_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid, LAT));

   assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_res));

   assert_reset_clear_R7: assert property (@(posedge clk)
      !rst_n |-> (!out_valid && out_res == '0 && tap_flat == '0));

endmodule

bind rnsfir_channel rnsfir_channel_chk #(.N(N), .TAPS(TAPS), .LAT(LATENCY)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_res    (in_res),
   .out_valid (out_valid),
   .out_res   (out_res),
   .tap_flat  (tap_flat)
);

// File: tb/rnsfir_channel_tb.sv
module rnsfir_channel_tb_top;

   localparam int N    = 4;
   localparam int TAPS = 4;
   localparam int MOD  = 15;
   localparam int LAT  = 3;
   localparam int QD   = 1024;
   localparam int C0 = 11, C1 = 15, C2 = 1, C3 = 6;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [N-1:0] in_res = '0;
   logic         out_valid;
   logic [N-1:0] out_res;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int hist [TAPS];
   int exp_val [QD];
   int exp_cyc [QD];
   int wr = 0;
   int rd = 0;
   int last_out = 0;
   int n_in = 0;
   int n_out = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rnsfir_channel #(
      .N(N), .TAPS(TAPS),
      .COEF_VEC({4'd6, 4'd1, 4'd15, 4'd11}),
      .CSA_STAGE(rnsfir_pkg::CSA_REG)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_res(in_res),
      .out_valid(out_valid), .out_res(out_res)
   );

   task automatic fail(input string req, input int act, input int expv);
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
   endtask

   task automatic check_outputs();
      if (out_valid) begin
         n_out++;
         checks++;
         if (rd == wr) fail("R5 unexpected out_valid", 1, 0);
         else begin
            if (exp_cyc[rd % QD] != cyc) fail("R5 latency", cyc, exp_cyc[rd % QD]);
            checks++;
            if (int'(out_res) != exp_val[rd % QD]) fail("R1/R3 result", int'(out_res), exp_val[rd % QD]);
            rd++;
         end
         checks++;
         if (out_res == '1) fail("R2 all-ones output", int'(out_res), 0);
         last_out = int'(out_res);
      end else begin
         checks++;
         if (int'(out_res) != last_out) fail("R6 hold", int'(out_res), last_out);
         checks++;
         if (rd != wr && exp_cyc[rd % QD] == cyc) fail("R5 missing out_valid", 0, 1);
      end
   endtask

   // one cycle: check at negedge, then drive
   task automatic cycle_drive(input bit v, input int x);
      @(negedge clk);
      check_outputs();
      in_valid = v;
      in_res   = N'(x);
      if (v) begin
         int s;
         for (int j = TAPS - 1; j > 0; j--) hist[j] = hist[j-1];
         hist[0] = x;
         s = C0 * hist[0] + C1 * hist[1] + C2 * hist[2] + C3 * hist[3];
         exp_val[wr % QD] = s % MOD;
         exp_cyc[wr % QD] = cyc + LAT;
         wr++;
         n_in++;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      in_valid = 1'b0;
      rst_n    = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int j = 0; j < TAPS; j++) hist[j] = 0;
      last_out = 0;
      checks++;
      if (out_valid !== 1'b0) fail("R7 out_valid after reset", int'(out_valid), 0);
      checks++;
      if (out_res !== '0) fail("R7 out_res after reset", int'(out_res), 0);
   endtask

   initial begin
      for (int j = 0; j < TAPS; j++) hist[j] = 0;
      do_reset();
      // R1 R3 R4: every ordered pair of codes, including all-ones, with idle gaps
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            cycle_drive(1'b1, a);
            if ((a + b) % 3 == 0) cycle_drive(1'b0, 0);
            cycle_drive(1'b1, b);
            if ((a * b) % 5 == 1) begin
               cycle_drive(1'b0, 0);
               cycle_drive(1'b0, 0);
            end
         end
      end
      // R6: idle drain
      repeat (8) cycle_drive(1'b0, 0);
      // R7: reset clears the history
      do_reset();
      cycle_drive(1'b1, 5);
      repeat (6) cycle_drive(1'b0, 0);
      checks++;
      if (last_out != (C0 * 5) % MOD) fail("R7 history cleared", last_out, (C0 * 5) % MOD);
      // R3: all-ones alone weights as zero
      cycle_drive(1'b1, 15);
      repeat (6) cycle_drive(1'b0, 0);
      checks++;
      if (last_out != (C1 * 5) % MOD) fail("R3 all-ones input", last_out, (C1 * 5) % MOD);
      checks++;
      if (n_out != n_in) fail("R5 output count", n_out, n_in);
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule